// File: doc/BRIEF.md
# Serial Host Access Port

This block is a 4-wire serial slave. It gives a host microcontroller access to a transceiver's control registers, its transmit data queue and its banked packet memory. SCLK, CSn and SI are brought into the system clock domain through a short synchroniser. Bits are assembled into bytes on the rising SCLK edge, and SO changes after the falling edge (mode 0). A transaction opens with a command byte. Bit 7 of that byte chooses memory or register space, and the remaining bits carry the address. While the command byte shifts in, the slave returns its status byte on SO.

Register addresses split into three groups. Low addresses are command strobes, which fire a one-cycle pulse. One address is a streaming write port into the transmit queue. All other addresses are 16-bit registers that are read or written high byte first. A memory access needs a second byte that carries the bank and a read-only flag. Data bytes follow the second byte. Within one CSn assertion, consecutive register words and memory bytes advance the address by one. Raising CSn at any point abandons the transaction.

Top module: `spi_host_port`

## Requirements
- R1: Data on SI and SO moves most significant bit first. SO is 0 while CSn is high. After reset no strobe, register write, queue write or memory write pulse is issued.
- R2: During the command byte, SO returns the status byte. Bit 7 of the status byte is 0, bit 6 is `osc_running_i`, bit 5 is the sticky underflow flag and bits 4:0 are `status_low_i`.
- R3: A one-cycle pulse on `tx_underflow_set_i` sets the underflow flag. The flag stays set until a strobe to address 0x09 clears it. If a set and a clear occur in the same cycle, the set wins.
- R4: A command byte with bit 7 = 0 and bits 5:0 in the range 0x00..0x0E produces one single-cycle `strobe_o` pulse, with that address on `strobe_addr_o`. The next byte under the same CSn is a new command byte, and it again returns the status byte.
- R5: A register write uses a command byte of {0, 0, addr[5:0]} followed by the high byte and then the low byte. After the low byte, `reg_we_o` pulses once with `reg_addr_o` equal to addr and `reg_wdata_o` equal to the assembled word.
- R6: A register read uses a command byte of {0, 1, addr[5:0]}. SO then returns `reg_rdata_i[15:8]` and then `reg_rdata_i[7:0]` for that address.
- R7: After each register word, the register address advances by one, modulo 64. After each memory data byte, the memory address advances by one, modulo 128.
- R8: Command 0x3E with bit 6 = 0 opens the transmit queue. Each following byte pulses `fifo_we_o` with that byte on `fifo_wdata_o`, and SO returns the status byte during every such byte.
- R9: A memory access uses a command byte of {1, addr[6:0]} and a second byte holding the bank in bits 7:6 and a read-only flag in bit 5. Bits 4:0 of the second byte are ignored. When the flag is 0, SO returns the stored byte during each data byte and the received byte replaces it.
- R10: When the read-only flag is 1, SO returns the stored bytes and `ram_we_o` never pulses.
- R11: Banks 0 and 1 hold 128 bytes each and bank 2 holds 112 bytes. A write to bank 2 at address 112 or above is dropped, and every write to bank 3 is dropped. Reads from such locations return 0 on SO.
- R12: Raising CSn, even in the middle of a byte or a word, returns the slave to waiting for a command byte with an empty bit count, and issues no write for the unfinished word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in (SI) |
| sdo_o | output | 1 | Serial data out (SO) |
| osc_running_i | input | 1 | Reference oscillator running, status bit 6 |
| tx_underflow_set_i | input | 1 | Pulse that sets the sticky underflow flag |
| status_low_i | input | 5 | Status bits 4:0 |
| strobe_o | output | 1 | One-cycle command strobe pulse |
| strobe_addr_o | output | 6 | Address of the strobe |
| reg_addr_o | output | 6 | Register address |
| reg_wdata_o | output | 16 | Register write word |
| reg_we_o | output | 1 | Register write pulse |
| reg_rdata_i | input | 16 | Register read word for `reg_addr_o` |
| fifo_we_o | output | 1 | Transmit queue write pulse |
| fifo_wdata_o | output | 8 | Transmit queue byte |
| ram_bank_o | output | 2 | Memory bank |
| ram_addr_o | output | 7 | Memory byte address |
| ram_wdata_o | output | 8 | Memory write byte |
| ram_we_o | output | 1 | Memory write pulse |
| ram_rdata_i | input | 8 | Memory read byte for bank and address |

## Verification
The assertions rely on each SCLK half period lasting several system clocks. With that margin, at most one byte completes within any few-cycle window, so the action pulses stay single and never coincide, and an address step always follows its write pulse before the next byte. They also rely on SI and CSn changing only while SCLK is low. The read ports are assumed to answer combinationally for the current address. The stimulus drives every edge from the falling system clock edge, holds each SCLK half for eight system clocks, and keeps CSn settled for several clocks around each transaction. The register and memory models in the bench answer at once.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = BYTE_W - 2;
  localparam int RAM_AW = BYTE_W - 1;
  localparam int BANK_W = 2;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_CMD,
    ST_REG_HI,
    ST_REG_LO,
    ST_FIFO,
    ST_RAM_BANK,
    ST_RAM_DATA
  } txn_state_e;
endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              cs_act_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sdo_o
);
  logic [SYNC_STAGES:0] sclk_p, csn_p, sdi_p;
  logic sclk_s, sclk_d, sdi_s, rise, fall, cs_start;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] shin_q;
  logic [BYTE_W-1:0] tx_q;
  logic ld1_q, ld2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p <= '0;
      csn_p  <= '1;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk_i};
      csn_p  <= {csn_p[SYNC_STAGES-1:0], csn_i};
      sdi_p  <= {sdi_p[SYNC_STAGES-1:0], sdi_i};
    end
  end

  assign sclk_s   = sclk_p[SYNC_STAGES-1];
  assign sclk_d   = sclk_p[SYNC_STAGES];
  assign sdi_s    = sdi_p[SYNC_STAGES-1];
  assign cs_act_o = ~csn_p[SYNC_STAGES-1];
  assign cs_start = csn_p[SYNC_STAGES] & ~csn_p[SYNC_STAGES-1];
  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;

  // Reload of tx_q waits two cycles so the controller's address step lands first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      shin_q     <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
      tx_q       <= '0;
      ld1_q      <= 1'b0;
      ld2_q      <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      ld1_q      <= cs_start | rx_valid_o;
      ld2_q      <= ld1_q;
      if (!cs_act_o) begin
        cnt_q <= '0;
      end else if (rise) begin
        shin_q <= {shin_q[BYTE_W-3:0], sdi_s};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {shin_q, sdi_s};
        end
      end
      if (ld2_q) tx_q <= tx_byte_i;
      else if (fall && cnt_q != '0) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdo_o = cs_act_o & tx_q[BYTE_W-1];

  assert_abort_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_o |=> (cnt_q == '0));
  assert_sdo_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_o |-> !sdo_o);
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
  import spi_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_running_i,
  input  logic              set_i,
  input  logic              flush_i,
  input  logic [4:0]        low_i,
  output logic [BYTE_W-1:0] status_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (flush_i) flag_q <= 1'b0;
  end

  assign status_o = {1'b0, osc_running_i, flag_q, low_i};

  assert_flag_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> status_o[5]);
  assert_flag_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !set_i |=> !status_o[5]);
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
  import spi_host_pkg::*;
#(
  parameter logic [REG_AW-1:0] STROBE_LAST = 6'h0E,
  parameter logic [REG_AW-1:0] FIFO_ADDR   = 6'h3E,
  parameter int                SEC_DEPTH   = 112
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [WORD_W-1:0] reg_rdata_i,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              strobe_o,
  output logic [REG_AW-1:0] strobe_addr_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              fifo_we_o,
  output logic [BYTE_W-1:0] fifo_wdata_o,
  output logic [BANK_W-1:0] ram_bank_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  output logic              ram_we_o
);
  localparam logic [RAM_AW-1:0] SEC_LIM = RAM_AW'(SEC_DEPTH);
  localparam logic [BANK_W-1:0] SEC_BANK = BANK_W'(2);
  localparam logic [BANK_W-1:0] NO_BANK  = BANK_W'(3);

  txn_state_e        state_q;
  logic              rd_q, ro_q, reg_step_q, ram_step_q, loc_ok;
  logic [BYTE_W-1:0] hi_q;

  assign loc_ok = (ram_bank_o != NO_BANK) &&
                  !((ram_bank_o == SEC_BANK) && (ram_addr_o >= SEC_LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_CMD;
      rd_q          <= 1'b0;
      ro_q          <= 1'b0;
      hi_q          <= '0;
      reg_step_q    <= 1'b0;
      ram_step_q    <= 1'b0;
      strobe_o      <= 1'b0;
      strobe_addr_o <= '0;
      reg_addr_o    <= '0;
      reg_wdata_o   <= '0;
      reg_we_o      <= 1'b0;
      fifo_we_o     <= 1'b0;
      fifo_wdata_o  <= '0;
      ram_bank_o    <= '0;
      ram_addr_o    <= '0;
      ram_wdata_o   <= '0;
      ram_we_o      <= 1'b0;
    end else begin
      strobe_o   <= 1'b0;
      reg_we_o   <= 1'b0;
      fifo_we_o  <= 1'b0;
      ram_we_o   <= 1'b0;
      reg_step_q <= 1'b0;
      ram_step_q <= 1'b0;
      if (reg_step_q) reg_addr_o <= reg_addr_o + 1'b1;
      if (ram_step_q) ram_addr_o <= ram_addr_o + 1'b1;
      if (!cs_act_i) begin
        state_q <= ST_CMD;
      end else if (rx_valid_i) begin
        unique case (state_q)
          ST_CMD: begin
            if (rx_byte_i[BYTE_W-1]) begin
              ram_addr_o <= rx_byte_i[RAM_AW-1:0];
              state_q    <= ST_RAM_BANK;
            end else if (rx_byte_i[REG_AW-1:0] <= STROBE_LAST) begin
              strobe_o      <= 1'b1;
              strobe_addr_o <= rx_byte_i[REG_AW-1:0];
            end else if (rx_byte_i[REG_AW-1:0] == FIFO_ADDR && !rx_byte_i[REG_AW]) begin
              state_q <= ST_FIFO;
            end else begin
              reg_addr_o <= rx_byte_i[REG_AW-1:0];
              rd_q       <= rx_byte_i[REG_AW];
              state_q    <= ST_REG_HI;
            end
          end
          ST_REG_HI: begin
            hi_q    <= rx_byte_i;
            state_q <= ST_REG_LO;
          end
          ST_REG_LO: begin
            if (!rd_q) begin
              reg_we_o    <= 1'b1;
              reg_wdata_o <= {hi_q, rx_byte_i};
            end
            reg_step_q <= 1'b1;
            state_q    <= ST_REG_HI;
          end
          ST_FIFO: begin
            fifo_we_o    <= 1'b1;
            fifo_wdata_o <= rx_byte_i;
          end
          ST_RAM_BANK: begin
            ram_bank_o <= rx_byte_i[BYTE_W-1 -: BANK_W];
            ro_q       <= rx_byte_i[BYTE_W-1-BANK_W];
            state_q    <= ST_RAM_DATA;
          end
          ST_RAM_DATA: begin
            ram_step_q <= 1'b1;
            if (!ro_q && loc_ok) begin
              ram_we_o    <= 1'b1;
              ram_wdata_o <= rx_byte_i;
            end
          end
          default: state_q <= ST_CMD;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_REG_HI:   tx_byte_o = rd_q ? reg_rdata_i[WORD_W-1:BYTE_W] : '0;
      ST_REG_LO:   tx_byte_o = rd_q ? reg_rdata_i[BYTE_W-1:0] : '0;
      ST_RAM_BANK: tx_byte_o = '0;
      ST_RAM_DATA: tx_byte_o = loc_ok ? ram_rdata_i : '0;
      default:     tx_byte_o = status_i;
    endcase
  end

  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  assert_one_action_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({strobe_o, reg_we_o, fifo_we_o, ram_we_o}));
  assert_reg_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> reg_addr_o == $past(reg_addr_o) + 1'b1);
  assert_ram_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> ram_addr_o == $past(ram_addr_o) + 1'b1);
  assert_ram_limit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_bank_o != NO_BANK) &&
                 !((ram_bank_o == SEC_BANK) && (ram_addr_o >= SEC_LIM)));
endmodule

// File: rtl/spi_host_port.sv
module spi_host_port
  import spi_host_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [REG_AW-1:0] STROBE_LAST = 6'h0E,
  parameter logic [REG_AW-1:0] FLUSH_ADDR  = 6'h09,
  parameter logic [REG_AW-1:0] FIFO_ADDR   = 6'h3E,
  parameter int                SEC_DEPTH   = 112
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              osc_running_i,
  input  logic              tx_underflow_set_i,
  input  logic [4:0]        status_low_i,
  output logic              strobe_o,
  output logic [REG_AW-1:0] strobe_addr_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [WORD_W-1:0] reg_rdata_i,
  output logic              fifo_we_o,
  output logic [BYTE_W-1:0] fifo_wdata_o,
  output logic [BANK_W-1:0] ram_bank_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  input  logic [BYTE_W-1:0] ram_rdata_i
);
  logic              cs_act, rx_valid, flush;
  logic [BYTE_W-1:0] rx_byte, tx_byte, status;

  assign flush = strobe_o && (strobe_addr_o == FLUSH_ADDR);

  spi_bit_engine #(.SYNC_STAGES(SYNC_STAGES)) u_bits (
    .clk_i, .rst_ni, .sclk_i, .csn_i, .sdi_i,
    .tx_byte_i (tx_byte),
    .cs_act_o  (cs_act),
    .rx_valid_o(rx_valid),
    .rx_byte_o (rx_byte),
    .sdo_o
  );

  spi_status_flags u_status (
    .clk_i, .rst_ni, .osc_running_i,
    .set_i   (tx_underflow_set_i),
    .flush_i (flush),
    .low_i   (status_low_i),
    .status_o(status)
  );

  spi_txn_ctrl #(
    .STROBE_LAST(STROBE_LAST),
    .FIFO_ADDR  (FIFO_ADDR),
    .SEC_DEPTH  (SEC_DEPTH)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .cs_act_i  (cs_act),
    .rx_valid_i(rx_valid),
    .rx_byte_i (rx_byte),
    .status_i  (status),
    .reg_rdata_i, .ram_rdata_i,
    .tx_byte_o (tx_byte),
    .strobe_o, .strobe_addr_o,
    .reg_addr_o, .reg_wdata_o, .reg_we_o,
    .fifo_we_o, .fifo_wdata_o,
    .ram_bank_o, .ram_addr_o, .ram_wdata_o, .ram_we_o
  );
endmodule

// File: tb/sim_spi_host_port.sv
module sim_spi_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic osc = 1'b1, txu_set = 1'b0;
  logic [4:0] st_low = 5'b01010;
  logic sdo_o, strobe_o, reg_we_o, fifo_we_o, ram_we_o;
  logic [5:0] strobe_addr_o, reg_addr_o;
  logic [15:0] reg_wdata_o, reg_rdata;
  logic [7:0] fifo_wdata_o, ram_wdata_o, ram_rdata;
  logic [1:0] ram_bank_o;
  logic [6:0] ram_addr_o;

  logic [15:0] regs_m [64];
  logic [7:0]  ram_m [4][128];
  int n_chk = 0, n_fail = 0;
  int strobe_cnt = 0, reg_we_cnt = 0, ram_we_cnt = 0, fifo_cnt = 0;
  logic [5:0] last_strobe;
  logic [7:0] fifo_log [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_host_port u0 (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi), .sdo_o,
    .osc_running_i(osc), .tx_underflow_set_i(txu_set), .status_low_i(st_low),
    .strobe_o, .strobe_addr_o, .reg_addr_o, .reg_wdata_o, .reg_we_o,
    .reg_rdata_i(reg_rdata), .fifo_we_o, .fifo_wdata_o,
    .ram_bank_o, .ram_addr_o, .ram_wdata_o, .ram_we_o, .ram_rdata_i(ram_rdata)
  );

  assign reg_rdata = regs_m[reg_addr_o];
  assign ram_rdata = ram_m[ram_bank_o][ram_addr_o];

  function automatic logic [7:0] pat(int b, int a);
    return {b[1:0], a[5:0]} ^ 8'h5C;
  endfunction

  always @(posedge clk) begin
    if (reg_we_o) begin regs_m[reg_addr_o] <= reg_wdata_o; reg_we_cnt++; end
    if (ram_we_o) begin ram_m[ram_bank_o][ram_addr_o] <= ram_wdata_o; ram_we_cnt++; end
    if (strobe_o) begin strobe_cnt++; last_strobe <= strobe_addr_o; end
    if (fifo_we_o) begin
      if (fifo_cnt < 8) fifo_log[fifo_cnt] <= fifo_wdata_o;
      fifo_cnt++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    csn = 1'b0; wait_clks(HALF);
  endtask

  task automatic cs_end();
    wait_clks(HALF); csn = 1'b1; wait_clks(2*HALF);
  endtask

  task automatic xfer_bits(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sdi = b[i]; wait_clks(HALF);
      r[i] = sdo_o; sclk = 1'b1; wait_clks(HALF); sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    xfer_bits(b, 8, r);
  endtask

  task automatic t_reset();
    chk("R1 sdo idle after reset", sdo_o, 0);
    chk("R1 no pulses after reset", strobe_cnt + reg_we_cnt + ram_we_cnt + fifo_cnt, 0);
  endtask

  task automatic t_status();
    logic [7:0] r;
    osc = 1'b0;
    cs_begin(); xfer(8'h01, r); cs_end();
    chk("R2 status osc off", r, 8'h0A);
    osc = 1'b1;
    cs_begin(); xfer(8'h01, r); cs_end();
    chk("R2 status osc on", r, 8'h4A);
  endtask

  task automatic t_strobe();
    logic [7:0] r;
    int s0 = strobe_cnt;
    cs_begin(); xfer(8'h03, r); cs_end();
    chk("R4 strobe count", strobe_cnt - s0, 1);
    chk("R4 strobe addr", last_strobe, 6'h03);
  endtask

  task automatic t_underflow();
    logic [7:0] r1, r2;
    @(negedge clk) txu_set = 1'b1;
    @(negedge clk) txu_set = 1'b0;
    cs_begin(); xfer(8'h02, r1); xfer(8'h0E, r2); cs_end();
    chk("R3 flag set", r1, 8'h6A);
    chk("R3 flag sticky across other strobe", r2, 8'h6A);
    cs_begin(); xfer(8'h09, r1); xfer(8'h00, r2); cs_end();
    chk("R3 flag seen before flush", r1, 8'h6A);
    chk("R3 R4 flush clears, next byte is command", r2, 8'h4A);
    chk("R4 last strobe in chain", last_strobe, 6'h00);
  endtask

  task automatic t_reg_write();
    logic [7:0] r;
    int w0 = reg_we_cnt;
    cs_begin();
    xfer(8'h15, r); chk("R2 status on reg write cmd", r, 8'h4A);
    xfer(8'hBE, r); xfer(8'hEF, r); xfer(8'h12, r); xfer(8'h34, r);
    cs_end();
    chk("R1 R5 word written msb first", regs_m[6'h15], 16'hBEEF);
    chk("R7 register auto increment", regs_m[6'h16], 16'h1234);
    chk("R5 write pulses", reg_we_cnt - w0, 2);
  endtask

  task automatic t_reg_read();
    logic [7:0] r0, r1, r2, r3, r4;
    cs_begin();
    xfer(8'h55, r0); xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3); xfer(8'h00, r4);
    cs_end();
    chk("R6 read high byte", r1, 8'hBE);
    chk("R6 read low byte", r2, 8'hEF);
    chk("R6 R7 read next word", {r3, r4}, 16'h1234);
  endtask

  task automatic t_fifo();
    logic [7:0] r0, r1, r2, r3;
    int f0 = fifo_cnt, w0 = reg_we_cnt;
    cs_begin();
    xfer(8'h3E, r0); xfer(8'h11, r1); xfer(8'h22, r2); xfer(8'h33, r3);
    cs_end();
    chk("R8 status on each queue byte", {r1, r2, r3}, 24'h4A4A4A);
    chk("R8 queue byte count", fifo_cnt - f0, 3);
    chk("R8 queue bytes in order", {fifo_log[0], fifo_log[1], fifo_log[2]}, 24'h112233);
    chk("R8 no register write", reg_we_cnt - w0, 0);
  endtask

  task automatic t_ram_rw();
    logic [7:0] r0, r1, r2, r3, r4;
    cs_begin();
    xfer(8'hFE, r0); xfer(8'h1F, r1); xfer(8'hAA, r2); xfer(8'hBB, r3); xfer(8'hCC, r4);
    cs_end();
    chk("R9 old byte at 7E", r2, pat(0, 126));
    chk("R9 R7 old byte at 00 after wrap", r4, pat(0, 0));
    chk("R9 written 7E", ram_m[0][126], 8'hAA);
    chk("R9 written 7F", ram_m[0][127], 8'hBB);
    chk("R7 written 00 after wrap", ram_m[0][0], 8'hCC);
  endtask

  task automatic t_ram_ro();
    logic [7:0] r0, r1, r2, r3;
    int w0 = ram_we_cnt;
    cs_begin();
    xfer(8'h85, r0); xfer(8'h7F, r1); xfer(8'hFF, r2); xfer(8'hFF, r3);
    cs_end();
    chk("R10 read bank1 05", r2, pat(1, 5));
    chk("R10 read bank1 06", r3, pat(1, 6));
    chk("R10 no write pulse", ram_we_cnt - w0, 0);
    chk("R10 bank1 05 unchanged", ram_m[1][5], pat(1, 5));
  endtask

  task automatic t_ram_limit();
    logic [7:0] r0, r1, r2, r3;
    int w0 = ram_we_cnt;
    cs_begin();
    xfer(8'hEF, r0); xfer(8'h80, r1); xfer(8'h77, r2); xfer(8'h88, r3);
    cs_end();
    chk("R11 bank2 last byte read", r2, pat(2, 111));
    chk("R11 bank2 beyond end reads 0", r3, 0);
    chk("R11 bank2 111 written", ram_m[2][111], 8'h77);
    chk("R11 bank2 112 untouched", ram_m[2][112], pat(2, 112));
    chk("R11 one write only", ram_we_cnt - w0, 1);
    w0 = ram_we_cnt;
    cs_begin();
    xfer(8'hC0, r0); xfer(8'hC0, r1); xfer(8'h11, r2);
    cs_end();
    chk("R11 bank3 reads 0", r2, 0);
    chk("R11 bank3 no write", ram_we_cnt - w0, 0);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    int w0 = reg_we_cnt;
    cs_begin(); xfer(8'h20, r); xfer(8'hDE, r); cs_end();
    chk("R12 no write for half word", reg_we_cnt - w0, 0);
    cs_begin(); xfer_bits(8'hFF, 5, r); cs_end();
    cs_begin();
    xfer(8'h21, r); chk("R12 fresh command returns status", r, 8'h4A);
    xfer(8'h12, r); xfer(8'h34, r);
    cs_end();
    chk("R12 fresh write lands", regs_m[6'h21], 16'h1234);
    chk("R12 aborted address untouched", regs_m[6'h20], 16'h0000);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) regs_m[i] = '0;
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 128; a++) ram_m[b][a] = pat(b, a);
    wait_clks(4);
    rst_ni = 1'b1;
    wait_clks(4);
    t_reset();
    t_status();
    t_strobe();
    t_underflow();
    t_reg_write();
    t_reg_read();
    t_fifo();
    t_ram_rw();
    t_ram_ro();
    t_ram_limit();
    t_abort();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end
endmodule